// File: doc/BRIEF.md
# Card Operating Conditions Register

This block sits on the card side of a storage-card interface and produces the 32-bit operating conditions word that goes back to the host during initialization. The word has four parts. The first is a fixed window of supported supply ranges, given as a parameter. The second is a busy/ready flag that rises when the card finishes powering up. The third is a capacity flag that shows whether the card is high-capacity. The fourth is a flag recording that the host has issued the voltage-check command.

Command decoding and response framing belong to neighbouring logic. That logic pulses `vchk_seen_i` when it decodes the voltage-check command. It raises `pwr_up_done_i` when internal power-up is finished. It drives `hi_cap_i` from the card's capacity configuration. The framing logic then samples `ocr_o` whenever it builds a response.

Top module: `card_opcond_reg`

## Requirements
- R1: While `rst_n` is low, `ocr_o` equals `VOLT_WIN` placed in bits 23:15, and every other bit is 0.
- R2: Bits 23:15 of `ocr_o` always equal the `VOLT_WIN` parameter. Bit 15 is the lowest 0.1 V range (2.7–2.8 V) and bit 23 is the highest (3.5–3.6 V). Changing the parameter changes only these bits.
- R3: Bits 6:0, 14:8 and 29:24 of `ocr_o` are 0 at all times.
- R4: Bit 31 (ready) reads 0 after reset. It reads 1 starting in the cycle after a rising clock edge at which `pwr_up_done_i` is high.
- R5: Once set, bit 31 stays 1 until reset, even if `pwr_up_done_i` falls.
- R6: While bit 31 is 1, bit 30 equals `hi_cap_i` in the same cycle, through combinational logic only.
- R7: While bit 31 is 0, bit 30 reads 0 whatever the value of `hi_cap_i`.
- R8: Bit 7 reads 0 after reset. It reads 1 starting in the cycle after a rising clock edge at which `vchk_seen_i` is high.
- R9: Once set, bit 7 stays 1 until reset. Further `vchk_seen_i` pulses and all other inputs leave it unchanged.
- R10: Asserting reset in the middle of operation clears bits 31, 30 and 7 together. The next power-up without a voltage-check pulse leaves bit 7 at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vchk_seen_i | input | 1 | One-cycle pulse: the voltage-check command was decoded |
| pwr_up_done_i | input | 1 | High when the internal power-up procedure has finished |
| hi_cap_i | input | 1 | Capacity configuration: 1 means high-capacity |
| ocr_o | output | 32 | Operating conditions word |

## Verification
Results arrive with two different latencies. The ready and voltage-check flags each pass through one register, so they appear one clock after the edge that samples their input. The capacity bit is combinational from `hi_cap_i` once ready is set, so it changes in the same cycle. The window and reserved bits never change. The bench drives inputs just after the falling edge and advances its own model on the rising edge. It compares every field of the word at the following falling edge. As a result, each one-register result is checked exactly one edge after its stimulus, and each combinational result is checked in the cycle it was driven.

// File: rtl/ocr_pkg.sv
package ocr_pkg;

  localparam int OCR_W     = 32;
  localparam int WIN_N     = 9;
  localparam int WIN_LO    = 15;
  localparam int WIN_HI    = WIN_LO + WIN_N - 1;
  localparam int RDY_BIT   = 31;
  localparam int CAP_BIT   = 30;
  localparam int DUALV_BIT = 7;

  // Bits carrying a meaning; every other bit is reserved.
  function automatic logic [OCR_W-1:0] used_mask();
    logic [OCR_W-1:0] m;
    m = '0;
    for (int i = WIN_LO; i <= WIN_HI; i++) m[i] = 1'b1;
    m[RDY_BIT]   = 1'b1;
    m[CAP_BIT]   = 1'b1;
    m[DUALV_BIT] = 1'b1;
    return m;
  endfunction

  // Ready gates the capacity flag so no stale value escapes.
  function automatic logic cap_view(logic rdy, logic hicap);
    return rdy & hicap;
  endfunction

  function automatic logic [OCR_W-1:0] pack_word(logic rdy, logic hicap,
                                                 logic dualv,
                                                 logic [WIN_N-1:0] win);
    logic [OCR_W-1:0] w;
    w = '0;
    w[WIN_HI:WIN_LO] = win;
    w[RDY_BIT]       = rdy;
    w[CAP_BIT]       = cap_view(rdy, hicap);
    w[DUALV_BIT]     = dualv;
    return w;
  endfunction

endpackage

// File: rtl/ocr_sticky_flag.sv
module ocr_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  output logic flag_o
);

  logic flag_q;
  logic set_evt;

  assign set_evt = set_i & ~flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (set_evt) flag_q <= 1'b1;
  end

  assign flag_o = flag_q;

  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q |=> flag_q); // R5

  AST_FLAG_TAKES_SET: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_q); // R4

endmodule

// File: rtl/ocr_word_pack.sv
module ocr_word_pack
  import ocr_pkg::*;
#(
  parameter logic [WIN_N-1:0] VOLT_WIN = '1
) (
  input  logic             rdy_i,
  input  logic             hicap_i,
  input  logic             dualv_i,
  output logic [OCR_W-1:0] word_o
);

  always_comb word_o = pack_word(rdy_i, hicap_i, dualv_i, VOLT_WIN);

  always_comb begin
    AST_RSV_CLEAR: assert ((word_o & ~used_mask()) == '0); // R3
  end

endmodule

// File: rtl/card_opcond_reg.sv
module card_opcond_reg
  import ocr_pkg::*;
#(
  parameter logic [WIN_N-1:0] VOLT_WIN = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vchk_seen_i,
  input  logic             pwr_up_done_i,
  input  logic             hi_cap_i,
  output logic [OCR_W-1:0] ocr_o
);

  logic rdy_flag;
  logic dualv_flag;

  ocr_sticky_flag u_ready (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (pwr_up_done_i),
    .flag_o (rdy_flag)
  );

  ocr_sticky_flag u_dualv (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (vchk_seen_i),
    .flag_o (dualv_flag)
  );

  ocr_word_pack #(.VOLT_WIN(VOLT_WIN)) u_pack (
    .rdy_i   (rdy_flag),
    .hicap_i (hi_cap_i),
    .dualv_i (dualv_flag),
    .word_o  (ocr_o)
  );

  AST_CAP_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
    !ocr_o[RDY_BIT] |-> !ocr_o[CAP_BIT]); // R7

  AST_CAP_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    ocr_o[RDY_BIT] |-> (ocr_o[CAP_BIT] == hi_cap_i)); // R6

  AST_DUALV_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ocr_o[DUALV_BIT] |=> ocr_o[DUALV_BIT]); // R9

  AST_DUALV_SET: assert property (@(posedge clk) disable iff (!rst_n)
    vchk_seen_i |=> ocr_o[DUALV_BIT]); // R8

  AST_WIN_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    ocr_o[WIN_HI:WIN_LO] == VOLT_WIN); // R2

  AST_RDY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ocr_o[RDY_BIT] |=> ocr_o[RDY_BIT]); // R5

endmodule

// File: tb/test_card_opcond_reg.sv
module test_card_opcond_reg;

  localparam int CLK_PERIOD = 10;
  localparam logic [8:0] ALT_WIN = 9'b0_0111_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vchk = 1'b0;
  logic pdone = 1'b0;
  logic hcap = 1'b0;
  logic [31:0] word;
  logic [31:0] word_alt;

  int n_tests = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  // Behavioural reference state
  bit m_rdy = 1'b0;
  bit m_dv = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  card_opcond_reg i_card_opcond_reg (
    .clk(clk), .rst_n(rst_n), .vchk_seen_i(vchk),
    .pwr_up_done_i(pdone), .hi_cap_i(hcap), .ocr_o(word)
  );

  card_opcond_reg #(.VOLT_WIN(ALT_WIN)) i_alt (
    .clk(clk), .rst_n(rst_n), .vchk_seen_i(vchk),
    .pwr_up_done_i(pdone), .hi_cap_i(hcap), .ocr_o(word_alt)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rdy <= 1'b0;
      m_dv  <= 1'b0;
    end else begin
      if (pdone) m_rdy <= 1'b1;
      if (vchk)  m_dv  <= 1'b1;
    end
  end

  function automatic logic [31:0] expect_word(bit rdy, bit dv, bit hc,
                                              logic [8:0] win);
    logic [31:0] e;
    e = 32'd0;
    for (int k = 0; k < 9; k++) e[15 + k] = win[k];
    e[31] = rdy;
    e[30] = rdy ? hc : 1'b0;
    e[7]  = dv;
    return e;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Field-by-field comparison on every falling edge
  always @(negedge clk) begin
    if (!finished) begin
      logic [31:0] e;
      e = expect_word(m_rdy, m_dv, hcap, 9'h1FF);
      chk("R2 window",   {23'd0, word[23:15]},     {23'd0, e[23:15]});
      chk("R3 reserved", word & 32'h3F00_7F7F,     32'd0);
      chk(m_rdy ? "R5 ready" : "R4 ready", {31'd0, word[31]}, {31'd0, e[31]});
      chk(m_rdy ? "R6 capacity" : "R7 capacity", {31'd0, word[30]}, {31'd0, e[30]});
      chk(m_dv ? "R9 dual-voltage" : "R8 dual-voltage", {31'd0, word[7]}, {31'd0, e[7]});
      chk("R2 alt window", word_alt, expect_word(m_rdy, m_dv, hcap, ALT_WIN));
    end
  end

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
    end
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    step(3);
    hcap = 1'b1;
    step(1);
    chk("R1 reset word", word, 32'h00FF_8000);
    rst_n = 1'b1;
    step(3);                         // R7: high capacity hidden while busy
    vchk = 1'b1; step(1); vchk = 1'b0;
    chk("R8 set after pulse", {31'd0, word[7]}, 32'd1);
    step(2);
    vchk = 1'b1; step(1); vchk = 1'b0;  // R9: second pulse no change
    step(2);
    pdone = 1'b1; step(1); pdone = 1'b0;
    chk("R4 ready after edge", {31'd0, word[31]}, 32'd1);
    step(3);                         // R5: held after input drops
    hcap = 1'b0; step(2);
    hcap = 1'b1; step(1);
    hcap = 1'b0; step(1);            // R6: capacity tracks same cycle
    hcap = 1'b1;
    rst_n = 1'b0; step(2);
    chk("R10 mid-run reset", word, 32'h00FF_8000);
    rst_n = 1'b1; step(2);
    pdone = 1'b1; step(4);
    chk("R10 ready without pulse", word, 32'hC0FF_8000);
    pdone = 1'b0; step(3);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule